// File: doc/BRIEF.md
# Mesh Barrier Step Synchronizer

This unit sits beside each compute core in a mesh of spiking-neuron cores. It replaces a shared step clock: cores agree on the simulated time step only by swapping barrier tokens with their direct neighbours. When the local core reports that it has finished its step, the unit runs a fixed number of exchange rounds. In each round it sends one token on every connected link and waits for one token from each of those links. `NUM_ROUNDS` is set to at least the mesh diameter. After that many rounds the completion of every core in the mesh has reached every node.

Links carry spikes and tokens in order, so a token that has arrived means the spikes sent before it on that link have arrived too. Spikes that are still queued locally are reported as a pending count. The unit holds back the step-advance pulse until that count is zero and all rounds are complete.

Each token carries a one-bit step parity. A token that a fast neighbour sends for the next step is held off and is never counted toward the current step. Links at the mesh edge are switched off by a parameter mask and are never waited on.

Top module: `barrier_sync`

## Requirements
- R1: No token leaves the node in a step until `done_i` has been sampled high in that step.
- R2: Tokens of round r+1 go out only after round r has been both sent and received on every enabled link. Exactly `NUM_ROUNDS` tokens are sent and accepted on each enabled link per step.
- R3: `step_par_o` resets to 0 and toggles with every advance. Every outgoing token carries `tok_par_o[d]` equal to `step_par_o`.
- R4: `tok_ready_o[d]` is high only when `tok_par_i[d]` equals `step_par_o` and no token of the current round has yet been taken from link d. This means at most one token per link per round.
- R5: The advance timing is fixed. Let k be the clock edge with the last handshake of the final round, and let p be the first edge at which `pend_cnt_i` is sampled as zero. `adv_o` is high during the cycle after edge max(k+1, p).
- R6: `adv_o` is a single-cycle pulse, high exactly once per step.
- R7: After an advance, no token leaves until `done_i` has been seen low and then high again.
- R8: A link whose bit in `DIR_EN` is 0 never shows `tok_valid_o` or `tok_ready_o` high and does not hold up any round.
- R9: During and just after reset, `adv_o`, `tok_valid_o` and `step_par_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Local core finished the current step |
| pend_cnt_i | input | CNT_W | Spike packets still to deliver locally |
| tok_valid_i | input | NUM_DIRS | Incoming token valid per link |
| tok_par_i | input | NUM_DIRS | Incoming token step parity per link |
| tok_ready_o | output | NUM_DIRS | Incoming token accepted per link |
| tok_valid_o | output | NUM_DIRS | Outgoing token valid per link |
| tok_par_o | output | NUM_DIRS | Outgoing token step parity per link |
| tok_ready_i | input | NUM_DIRS | Outgoing token taken per link |
| adv_o | output | 1 | Step-advance pulse to the local core |
| step_par_o | output | 1 | Parity of the current step |

## Verification
The neighbour model in the bench answers each round only after it has been served the previous one. The bench varies when the local core finishes, when neighbours arrive, how long outgoing tokens are back-pressured, and when the pending count drains. It predicts the exact advance cycle from these. A design that skipped the pending check, or finished a round before every link completed, would pulse early. A design that mixed up rounds would send the wrong number of tokens.

Directed cases cover several faults. A token with the wrong parity must be refused; an unchecked parity would let a next-step token close the current step. A second token in one round must be refused, since accepting it would count it twice. The bench keeps `done_i` high after an advance to catch a design that starts the next step without seeing done drop. A disabled edge link must stay silent.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXCH  = 2'd1,
    ST_DRAIN = 2'd2
  } bsync_state_e;

  function automatic int rnd_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bsync_link_rx.sv
module bsync_link_rx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic par_i,
  input  logic step_par_i,
  input  logic clr_i,
  output logic ready_o,
  output logic have_o
);
  logic have_q;

  // only a token of the current step, and one per round
  assign ready_o = !have_q && (par_i == step_par_i);
  assign have_o  = have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                have_q <= 1'b0;
    else if (clr_i)             have_q <= 1'b0;
    else if (valid_i && ready_o) have_q <= 1'b1;
  end
endmodule

// File: rtl/bsync_link_tx.sv
module bsync_link_tx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic clr_i,
  input  logic step_par_i,
  input  logic ready_i,
  output logic valid_o,
  output logic par_o,
  output logic sent_o
);
  logic sent_q;

  assign valid_o = send_i && !sent_q;
  assign par_o   = step_par_i;
  assign sent_o  = sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sent_q <= 1'b0;
    else if (clr_i)              sent_q <= 1'b0;
    else if (valid_o && ready_i) sent_q <= 1'b1;
  end
endmodule

// File: rtl/bsync_ctrl.sv
module bsync_ctrl
  import bsync_pkg::*;
#(
  parameter int NUM_ROUNDS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic pend_zero_i,
  input  logic rnd_done_i,
  output logic send_o,
  output logic clr_o,
  output logic adv_o,
  output logic step_par_o
);
  localparam int RND_W = rnd_width(NUM_ROUNDS);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);

  bsync_state_e state_q, state_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic armed_q, armed_d;
  logic par_q, par_d;
  logic adv_q, adv_d;

  assign send_o     = (state_q == ST_EXCH);
  assign clr_o      = (state_q == ST_EXCH) && rnd_done_i;
  assign adv_o      = adv_q;
  assign step_par_o = par_q;

  always_comb begin
    state_d = state_q;
    rnd_d   = rnd_q;
    armed_d = armed_q || !done_i;
    par_d   = par_q;
    adv_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (done_i && armed_q) begin
          state_d = ST_EXCH;
          rnd_d   = '0;
        end
      end
      ST_EXCH: begin
        if (rnd_done_i) begin
          if (rnd_q == RND_LAST) begin
            if (pend_zero_i) begin
              adv_d   = 1'b1;
              par_d   = !par_q;
              armed_d = 1'b0;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_DRAIN;
            end
          end else begin
            rnd_d = rnd_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (pend_zero_i) begin
          adv_d   = 1'b1;
          par_d   = !par_q;
          armed_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      armed_q <= 1'b0;
      par_q   <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rnd_q   <= rnd_d;
      armed_q <= armed_d;
      par_q   <= par_d;
      adv_q   <= adv_d;
    end
  end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync #(
  parameter int                     NUM_DIRS   = 4,
  parameter logic [NUM_DIRS-1:0]    DIR_EN     = '1,
  parameter int                     NUM_ROUNDS = 4,
  parameter int                     CNT_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [CNT_W-1:0]    pend_cnt_i,
  input  logic [NUM_DIRS-1:0] tok_valid_i,
  input  logic [NUM_DIRS-1:0] tok_par_i,
  output logic [NUM_DIRS-1:0] tok_ready_o,
  output logic [NUM_DIRS-1:0] tok_valid_o,
  output logic [NUM_DIRS-1:0] tok_par_o,
  input  logic [NUM_DIRS-1:0] tok_ready_i,
  output logic                adv_o,
  output logic                step_par_o
);
  logic [NUM_DIRS-1:0] have;
  logic [NUM_DIRS-1:0] sent;
  logic send, clr, par;
  logic rnd_done;

  assign rnd_done   = (&have) && (&sent);
  assign step_par_o = par;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_link
    if (DIR_EN[d]) begin : g_on
      bsync_link_rx u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (tok_valid_i[d]),
        .par_i      (tok_par_i[d]),
        .step_par_i (par),
        .clr_i      (clr),
        .ready_o    (tok_ready_o[d]),
        .have_o     (have[d])
      );
      bsync_link_tx u_tx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .send_i     (send),
        .clr_i      (clr),
        .step_par_i (par),
        .ready_i    (tok_ready_i[d]),
        .valid_o    (tok_valid_o[d]),
        .par_o      (tok_par_o[d]),
        .sent_o     (sent[d])
      );
    end else begin : g_off
      // edge link: silent and never waited on
      assign tok_ready_o[d] = 1'b0;
      assign tok_valid_o[d] = 1'b0;
      assign tok_par_o[d]   = 1'b0;
      assign have[d]        = 1'b1;
      assign sent[d]        = 1'b1;
    end
  end

  bsync_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done_i),
    .pend_zero_i (pend_cnt_i == '0),
    .rnd_done_i  (rnd_done),
    .send_o      (send),
    .clr_o       (clr),
    .adv_o       (adv_o),
    .step_par_o  (par)
  );
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int                  NUM_DIRS = 4,
  parameter logic [NUM_DIRS-1:0] DIR_EN   = '1,
  parameter int                  CNT_W    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                done_i,
  input logic [CNT_W-1:0]    pend_cnt_i,
  input logic [NUM_DIRS-1:0] tok_valid_i,
  input logic [NUM_DIRS-1:0] tok_par_i,
  input logic [NUM_DIRS-1:0] tok_ready_o,
  input logic [NUM_DIRS-1:0] tok_valid_o,
  input logic [NUM_DIRS-1:0] tok_par_o,
  input logic [NUM_DIRS-1:0] tok_ready_i,
  input logic                adv_o,
  input logic                step_par_o
);
  AST_ADV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !adv_o); // R6

  AST_ADV_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adv_o) |-> $past(pend_cnt_i) == '0); // R5

  AST_PAR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adv_o) |-> step_par_o != $past(step_par_o)); // R3

  AST_ADV_NOT_DONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adv_o) |-> $past(done_i)); // R7

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tok_valid_o[d] && !tok_ready_i[d]) |=> tok_valid_o[d]); // R2

    AST_TX_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tok_valid_o[d] |-> tok_par_o[d] == step_par_o); // R3

    AST_RX_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tok_valid_i[d] && tok_ready_o[d]) |-> tok_par_i[d] == step_par_o); // R4

    AST_RX_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tok_valid_i[d] && tok_ready_o[d]) |=> !tok_ready_o[d]); // R4

    if (!DIR_EN[d]) begin : g_off
      AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tok_valid_o[d] && !tok_ready_o[d]); // R8
    end
  end
endmodule

bind barrier_sync barrier_sync_chk #(
  .NUM_DIRS (NUM_DIRS),
  .DIR_EN   (DIR_EN),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/barrier_sync_tb.sv
`timescale 1ns/100ps
module barrier_sync_tb;
  localparam int ND = 4;
  localparam logic [ND-1:0] EN = 4'b1011;
  localparam int NR = 3;
  localparam int CW = 8;
  localparam int NEN = 3;
  localparam int LIM = 300;

  // fields: done_dly, in_dly, rdy_dly, pend_val, pend_until
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd5, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd1, 8'd8, 8'd0, 8'd0, 8'd0},
    {8'd1, 8'd0, 8'd6, 8'd0, 8'd0},
    {8'd1, 8'd0, 8'd0, 8'd3, 8'd30},
    {8'd2, 8'd3, 8'd2, 8'd1, 8'd4}
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic done_i;
  logic [CW-1:0] pend_cnt_i;
  logic [ND-1:0] tok_valid_i, tok_par_i, tok_ready_o;
  logic [ND-1:0] tok_valid_o, tok_par_o, tok_ready_i;
  logic adv_o, step_par_o;

  int checks = 0;
  int errors = 0;
  logic exp_par = 1'b0;

  always #2.5 clk_i = ~clk_i;

  barrier_sync #(.NUM_DIRS(ND), .DIR_EN(EN), .NUM_ROUNDS(NR), .CNT_W(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .pend_cnt_i(pend_cnt_i),
    .tok_valid_i(tok_valid_i), .tok_par_i(tok_par_i), .tok_ready_o(tok_ready_o),
    .tok_valid_o(tok_valid_o), .tok_par_o(tok_par_o), .tok_ready_i(tok_ready_i),
    .adv_o(adv_o), .step_par_o(step_par_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_step(input logic [39:0] v, input bit hold);
    int done_dly = int'(v[39:32]);
    int in_dly   = int'(v[31:24]);
    int rdy_dly  = int'(v[23:16]);
    int pend_val = int'(v[15:8]);
    int pend_unt = int'(v[7:0]);
    int rin[ND];
    int rout[ND];
    int k = -1, adv_it = -1, n_adv = 0, total = 0, tail;
    int r1_bad = 0, r2_bad = 0, par_bad = 0, dis_bad = 0, r7_bad = 0;
    int p, expc;
    bit done_seen = 0;
    tail = hold ? 14 : 6;
    for (int d = 0; d < ND; d++) begin rin[d] = 0; rout[d] = 0; end
    for (int i = 0; i < LIM && (adv_it < 0 || i < adv_it + tail); i++) begin
      @(negedge clk_i);
      done_i     = (adv_it >= 0) ? hold : (i >= done_dly);
      pend_cnt_i = (i < pend_unt) ? CW'(pend_val) : '0;
      for (int d = 0; d < ND; d++) begin
        tok_valid_i[d] = EN[d] && rin[d] < NR && i >= in_dly && (rin[d] == 0 || rout[d] >= rin[d]);
        tok_par_i[d]   = exp_par;
        tok_ready_i[d] = (i >= rdy_dly);
      end
      #1;
      if (adv_o) begin n_adv++; if (adv_it < 0) adv_it = i; end
      if (|tok_valid_o && !done_seen) r1_bad++;
      if (hold && adv_it >= 0 && |tok_valid_o) r7_bad++;
      for (int d = 0; d < ND; d++) begin
        if (!EN[d] && (tok_valid_o[d] || tok_ready_o[d])) dis_bad++;
        if (tok_valid_i[d] && tok_ready_o[d]) begin rin[d]++; total++; end
        if (tok_valid_o[d] && tok_ready_i[d]) begin
          if (tok_par_o[d] != exp_par) par_bad++;
          for (int e = 0; e < ND; e++)
            if (EN[e] && (rin[e] < rout[d] || rout[e] < rout[d])) r2_bad++;
          rout[d]++; total++;
        end
      end
      if (total == 2 * NR * NEN && k < 0) k = i;
      if (done_i) done_seen = 1;
    end
    p = (pend_val == 0) ? 0 : pend_unt;
    expc = ((k + 1 > p) ? k + 1 : p) + 1;
    chk(n_adv == 1, "R6 advance count", n_adv, 1);
    chk(k >= 0 && adv_it == expc, "R5 advance cycle", adv_it, expc);
    chk(r1_bad == 0, "R1 token before done", r1_bad, 0);
    chk(r2_bad == 0, "R2 round order", r2_bad, 0);
    chk(par_bad == 0, "R3 token parity", par_bad, 0);
    chk(dis_bad == 0, "R8 disabled link active", dis_bad, 0);
    for (int d = 0; d < ND; d++)
      if (EN[d]) chk(rin[d] == NR && rout[d] == NR, "R2 tokens per link", rin[d] * 10 + rout[d], NR * 11);
    chk(step_par_o == !exp_par, "R3 step parity toggle", int'(step_par_o), int'(!exp_par));
    if (hold) chk(r7_bad == 0, "R7 restart with done held", r7_bad, 0);
    exp_par = !exp_par;
    @(negedge clk_i);
    done_i = 1'b0; tok_valid_i = '0; pend_cnt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; done_i = 1'b0; pend_cnt_i = '0;
    tok_valid_i = '0; tok_par_i = '0; tok_ready_i = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(adv_o == 0 && tok_valid_o == '0 && step_par_o == 0, "R9 reset outputs",
        int'({adv_o, tok_valid_o, step_par_o}), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(tok_ready_o == EN, "R8 ready after reset", int'(tok_ready_o), int'(EN));
    chk(adv_o == 0 && tok_valid_o == '0, "R9 idle after reset", int'({adv_o, tok_valid_o}), 0);

    // wrong parity must be refused
    @(negedge clk_i);
    tok_valid_i[0] = 1'b1; tok_par_i[0] = 1'b1;
    #1;
    chk(tok_ready_o[0] == 0, "R4 wrong parity refused", int'(tok_ready_o[0]), 0);
    chk(tok_ready_o[1] == 1, "R4 matching parity ready", int'(tok_ready_o[1]), 1);
    @(negedge clk_i);
    tok_valid_i = '0; tok_par_i = '0;

    for (int n = 0; n < 6; n++) run_step(VEC[n], 1'b0);
    run_step({8'd1, 8'd0, 8'd0, 8'd0, 8'd0}, 1'b1);

    // second token in one round must be refused
    @(negedge clk_i);
    done_i = 1'b0; tok_valid_i[0] = 1'b1; tok_par_i[0] = exp_par;
    #1;
    chk(tok_ready_o[0] == 1, "R4 first token accepted", int'(tok_ready_o[0]), 1);
    @(negedge clk_i); #1;
    chk(tok_ready_o[0] == 0, "R4 second token refused", int'(tok_ready_o[0]), 0);
    @(negedge clk_i);
    tok_valid_i = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule